// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a write-only three-wire serial slave that loads a small bank of 12-bit configuration registers. A host pulls the load strobe low to open a frame. It then clocks in a 3-bit start address, one reserved bit and one or more 12-bit data words. Every bit is sampled on a rising edge of the serial clock. After each complete word, the target address steps to the next register, so a single frame can fill the whole bank.

Incoming words go into a shadow copy of the bank. The live registers change only when the load strobe returns high. A word cut short by the strobe is dropped. Setting bit 0 of register 0 returns every register to its default.

For a programmable window after reset the port ignores traffic, which covers the settling time at power-up. The serial pins are asynchronous to the system clock. They pass through two-flop synchronizers and are oversampled, so all state lives in the system clock domain.

Top module: `serial_cfg_port`

## Requirements
- R1: A frame starts when `load_i` falls. Its bits are taken on rising edges of `sclk_i`, in this order: address bit 0, address bit 1, address bit 2, a reserved bit that is ignored, then data bit 0 through data bit 11. Each field is sent least significant bit first.
- R2: Edges on `sclk_i` while `load_i` is high leave the registers and the framing unchanged.
- R3: After each complete 12-bit word in a frame, the next word goes to the following address. The address wraps from 7 to 0.
- R4: Words addressed to 4, 5, 6 or 7 are dropped and change no register.
- R5: Received words change `cfg_o` only after `load_i` rises. Until then the previous values stay visible.
- R6: After reset, registers 0, 1 and 3 read 0 and register 2 reads 128. Register i sits in `cfg_o[12*i +: 12]`.
- R7: If the value committed to register 0 has bit 0 set, all registers return to their R6 defaults, and register 0 bit 0 reads back as 0.
- R8: A frame whose `load_i` falling edge comes within the first `LOCK_CYCLES` clocks after reset is ignored in full.
- R9: A trailing word with fewer than 12 bits when `load_i` rises is discarded. Earlier complete words in the same frame still commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load strobe; low for the length of a frame, rising edge commits |
| sclk_i | input | 1 | Serial clock; data taken on its rising edge |
| sdata_i | input | 1 | Serial data |
| cfg_o | output | 48 | Live register bank, register i at bits 12*i+11 down to 12*i |

## Verification
The assertions assume that each serial pin holds its level for at least three system clocks. They also assume that `sdata_i` is stable around each rising `sclk_i` edge, and that `load_i` never changes in the same synchronized cycle as an `sclk_i` edge. Under these assumptions every serial edge is seen exactly once and in order. The stimulus holds each half period of `sclk_i` for eight clocks, changes `sdata_i` only on the falling half, and leaves eight clocks between a strobe edge and the nearest clock edge.

// File: rtl/serial_cfg_port_pkg.sv
package serial_cfg_port_pkg;

  localparam int WORD_W = 12;
  localparam int ADDR_W = 3;
  localparam int HDR_W  = ADDR_W + 1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_HDR,
    RX_DATA,
    RX_SKIP
  } rx_state_e;

  // Serial fields arrive LSB first: each new bit enters at the top.
  function automatic word_t shift_in(word_t w, logic b);
    return {b, w[WORD_W-1:1]};
  endfunction

  function automatic addr_t next_addr(addr_t a);
    return a + addr_t'(1);
  endfunction

  function automatic word_t reset_value(int idx, int clamp_idx, int clamp_val);
    return (idx == clamp_idx) ? word_t'(clamp_val) : '0;
  endfunction

endpackage

// File: rtl/serial_cfg_port_sync.sv
module serial_cfg_port_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end

endmodule

// File: rtl/serial_cfg_port_lockout.sv
module serial_cfg_port_lockout #(
  parameter int LOCK_CYCLES = 125000
) (
  input  logic clk,
  input  logic rst_n,
  output logic locked_o
);

  localparam int CNT_W = $clog2(LOCK_CYCLES + 2);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOCK_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign locked_o = (cnt_q != LIMIT);

endmodule

// File: rtl/serial_cfg_port_rx.sv
module serial_cfg_port_rx
  import serial_cfg_port_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  logic  sclk_i,
  input  logic  sdata_i,
  input  logic  locked_i,
  output logic  word_evt_o,
  output addr_t word_addr_o,
  output word_t word_data_o,
  output logic  commit_evt_o
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);

  logic             load_d, sclk_d;
  logic             sclk_rise, load_fall, load_rise;
  rx_state_e        st_q;
  logic [CNT_W-1:0] bit_cnt_q;
  addr_t            ptr_q;
  word_t            shreg_q;

  assign sclk_rise = sclk_i & ~sclk_d;
  assign load_fall = ~load_i & load_d;
  assign load_rise = load_i & ~load_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_d       <= 1'b1;
      sclk_d       <= 1'b0;
      st_q         <= RX_IDLE;
      bit_cnt_q    <= '0;
      ptr_q        <= '0;
      shreg_q      <= '0;
      word_evt_o   <= 1'b0;
      word_addr_o  <= '0;
      word_data_o  <= '0;
      commit_evt_o <= 1'b0;
    end else begin
      load_d       <= load_i;
      sclk_d       <= sclk_i;
      word_evt_o   <= 1'b0;
      commit_evt_o <= load_rise;
      if (load_i) begin
        st_q      <= RX_IDLE;
        bit_cnt_q <= '0;
      end else if (load_fall) begin
        st_q      <= locked_i ? RX_SKIP : RX_HDR;
        bit_cnt_q <= '0;
      end else if (sclk_rise) begin
        case (st_q)
          RX_HDR: begin
            if (bit_cnt_q != HDR_LAST) begin
              ptr_q <= {sdata_i, ptr_q[ADDR_W-1:1]};
            end
            if (bit_cnt_q == HDR_LAST) begin
              st_q      <= RX_DATA;
              bit_cnt_q <= '0;
            end else begin
              bit_cnt_q <= bit_cnt_q + CNT_W'(1);
            end
          end
          RX_DATA: begin
            shreg_q <= shift_in(shreg_q, sdata_i);
            if (bit_cnt_q == WORD_LAST) begin
              word_evt_o  <= 1'b1;
              word_addr_o <= ptr_q;
              word_data_o <= shift_in(shreg_q, sdata_i);
              ptr_q       <= next_addr(ptr_q);
              bit_cnt_q   <= '0;
            end else begin
              bit_cnt_q <= bit_cnt_q + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/serial_cfg_port_bank.sv
module serial_cfg_port_bank
  import serial_cfg_port_pkg::*;
#(
  parameter int NUM_REGS  = 4,
  parameter int CLAMP_IDX = 2,
  parameter int CLAMP_VAL = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       word_evt_i,
  input  addr_t                      word_addr_i,
  input  word_t                      word_data_i,
  input  logic                       commit_i,
  output logic [NUM_REGS*WORD_W-1:0] regs_o
);

  logic [NUM_REGS-1:0][WORD_W-1:0] nxt;
  logic                            sw_reset;

  // Committing a set bit 0 into register 0 restores every default.
  assign sw_reset = nxt[0][0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    word_t live_q, shadow_q;
    logic  pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= '0;
        pend_q   <= 1'b0;
      end else if (commit_i) begin
        pend_q <= 1'b0;
      end else if (word_evt_i && word_addr_i == ADDR_W'(i)) begin
        shadow_q <= word_data_i;
        pend_q   <= 1'b1;
      end
    end

    assign nxt[i] = pend_q ? shadow_q : live_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q <= reset_value(i, CLAMP_IDX, CLAMP_VAL);
      end else if (commit_i) begin
        live_q <= sw_reset ? reset_value(i, CLAMP_IDX, CLAMP_VAL) : nxt[i];
      end
    end

    assign regs_o[i*WORD_W +: WORD_W] = live_q;
  end

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import serial_cfg_port_pkg::*;
#(
  parameter int NUM_REGS    = 4,
  parameter int CLAMP_IDX   = 2,
  parameter int CLAMP_VAL   = 128,
  parameter int LOCK_CYCLES = 125000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic                       sclk_i,
  input  logic                       sdata_i,
  output logic [NUM_REGS*WORD_W-1:0] cfg_o
);

  logic [2:0] pins_s;
  logic       load_s, sclk_s, sdata_s;
  logic       locked;
  logic       word_evt;
  addr_t      word_addr;
  word_t      word_data;
  logic       commit_evt;

  serial_cfg_port_sync #(
    .W       (3),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({load_i, sclk_i, sdata_i}),
    .q_o   (pins_s)
  );

  assign load_s  = pins_s[2];
  assign sclk_s  = pins_s[1];
  assign sdata_s = pins_s[0];

  serial_cfg_port_lockout #(
    .LOCK_CYCLES (LOCK_CYCLES)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .locked_o (locked)
  );

  serial_cfg_port_rx u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_s),
    .sclk_i       (sclk_s),
    .sdata_i      (sdata_s),
    .locked_i     (locked),
    .word_evt_o   (word_evt),
    .word_addr_o  (word_addr),
    .word_data_o  (word_data),
    .commit_evt_o (commit_evt)
  );

  serial_cfg_port_bank #(
    .NUM_REGS  (NUM_REGS),
    .CLAMP_IDX (CLAMP_IDX),
    .CLAMP_VAL (CLAMP_VAL)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_evt_i  (word_evt),
    .word_addr_i (word_addr),
    .word_data_i (word_data),
    .commit_i    (commit_evt),
    .regs_o      (cfg_o)
  );

endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk #(
  parameter int NUM_REGS = 4,
  parameter int WORD_W   = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       load_s,
  input logic                       locked,
  input logic                       word_evt,
  input logic                       commit_evt,
  input logic [NUM_REGS*WORD_W-1:0] cfg_o
);

  a_r5_change_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o != $past(cfg_o)) |-> $past(commit_evt));

  a_r8_no_words_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !word_evt);

  a_r8_regs_hold_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(cfg_o));

  a_r7_reset_bit_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[0] == 1'b0);

  a_r2_words_only_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    word_evt |-> $past(!load_s));

endmodule

bind serial_cfg_port serial_cfg_port_chk #(
  .NUM_REGS (NUM_REGS),
  .WORD_W   (serial_cfg_port_pkg::WORD_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_s     (load_s),
  .locked     (locked),
  .word_evt   (word_evt),
  .commit_evt (commit_evt),
  .cfg_o      (cfg_o)
);

// File: tb/serial_cfg_port_bench.sv
module serial_cfg_port_bench;

  localparam int NREG = 4;
  localparam int LOCK = 2000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            load_i, sclk_i, sdata_i;
  logic [NREG*12-1:0] cfg_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  int exp_r [NREG];
  int wbuf  [16];

  always #4 clk = ~clk;

  serial_cfg_port #(
    .NUM_REGS    (NREG),
    .CLAMP_IDX   (2),
    .CLAMP_VAL   (128),
    .LOCK_CYCLES (LOCK)
  ) u_serial_cfg_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .sclk_i  (sclk_i),
    .sdata_i (sdata_i),
    .cfg_o   (cfg_o)
  );

  function automatic int dflt(int i);
    return (i == 2) ? 128 : 0;
  endfunction

  task automatic chk_all(string tag);
    for (int i = 0; i < NREG; i++) begin
      int got;
      got = int'(cfg_o[i*12 +: 12]);
      checks++;
      if (got != exp_r[i]) begin
        errors++;
        $display("FAIL %s reg%0d actual=%03h expected=%03h", tag, i, got, exp_r[i]);
      end
    end
  endtask

  task automatic put_bit(bit b);
    sdata_i = b;
    repeat (8) @(negedge clk);
    sclk_i = 1'b1;
    repeat (8) @(negedge clk);
    sclk_i = 1'b0;
  endtask

  // One frame: header, nw full words from wbuf, then 'partial' extra bits.
  task automatic frame(int start, int nw, int partial, bit mid, string tag);
    @(negedge clk);
    load_i = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 3; i++) put_bit(bit'((start >> i) & 1));
    put_bit(1'b0);
    for (int w = 0; w < nw; w++)
      for (int b = 0; b < 12; b++) put_bit(bit'((wbuf[w] >> b) & 1));
    for (int b = 0; b < partial; b++) put_bit(1'b1);
    repeat (8) @(negedge clk);
    if (mid) chk_all(tag);
    load_i = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic model(int start, int nw);
    int pv [NREG];
    bit pf [NREG];
    for (int a = 0; a < NREG; a++) begin pv[a] = 0; pf[a] = 1'b0; end
    for (int i = 0; i < nw; i++) begin
      int a;
      a = (start + i) % 8;
      if (a < NREG) begin pv[a] = wbuf[i]; pf[a] = 1'b1; end
    end
    for (int a = 0; a < NREG; a++) if (pf[a]) exp_r[a] = pv[a];
    if ((exp_r[0] & 1) != 0)
      for (int a = 0; a < NREG; a++) exp_r[a] = dflt(a);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; load_i = 1'b1; sclk_i = 1'b0; sdata_i = 1'b0;
    for (int i = 0; i < NREG; i++) exp_r[i] = dflt(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R6 reset defaults");

    // R8: frame opened inside the lockout window is ignored
    wbuf[0] = 12'h5A5;
    frame(1, 1, 0, 1'b0, "R8");
    chk_all("R8 lockout frame ignored");
    repeat (LOCK) @(negedge clk);

    // R2: clock noise with the strobe high
    for (int i = 0; i < 20; i++) begin
      sdata_i = bit'(i & 1);
      repeat (4) @(negedge clk);
      sclk_i = 1'b1;
      repeat (4) @(negedge clk);
      sclk_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    chk_all("R2 edges with strobe high");
    wbuf[0] = 12'h3C6;
    frame(3, 1, 0, 1'b0, "R2");
    model(3, 1);
    chk_all("R2 framing intact after noise");

    // R1: walking ones through each register (bit order, address decode)
    for (int r = 0; r < NREG; r++)
      for (int b = 0; b < 12; b++) begin
        if (r == 0 && b == 0) continue;
        wbuf[0] = 1 << b;
        frame(r, 1, 0, 1'b0, "R1");
        model(r, 1);
        chk_all("R1 walking one");
      end

    // R4: addresses beyond the bank are dropped
    for (int a = 4; a < 8; a++) begin
      wbuf[0] = 12'h700 + a;
      frame(a, 1, 0, 1'b0, "R4");
      model(a, 1);
      chk_all("R4 out-of-range address");
    end

    // R5: nothing visible before the strobe rises
    wbuf[0] = 12'hABC;
    frame(3, 1, 0, 1'b1, "R5 before strobe");
    model(3, 1);
    chk_all("R5 after strobe");

    // R3: auto-increment and wrap
    wbuf[0] = 12'h111; wbuf[1] = 12'h222; wbuf[2] = 12'h333;
    frame(1, 3, 0, 1'b0, "R3");
    model(1, 3);
    chk_all("R3 increment");
    for (int i = 0; i < 8; i++) wbuf[i] = 12'h810 + 12'h102 * i;
    wbuf[6] = 12'h0A4;
    frame(2, 8, 0, 1'b0, "R3");
    model(2, 8);
    chk_all("R3 wrap 7 to 0");

    // R9: partial trailing word dropped
    wbuf[0] = 12'h0F0;
    frame(3, 1, 7, 1'b0, "R9");
    model(3, 1);
    chk_all("R9 partial after full word");
    frame(1, 0, 11, 1'b0, "R9");
    chk_all("R9 lone partial word");

    // R7: software reset, alone and with other words in the frame
    wbuf[0] = 12'h001;
    frame(0, 1, 0, 1'b0, "R7");
    model(0, 1);
    chk_all("R7 soft reset");
    wbuf[0] = 12'h012; wbuf[1] = 12'h444; wbuf[2] = 12'h055; wbuf[3] = 12'h666;
    frame(0, 4, 0, 1'b0, "R7");
    model(0, 4);
    wbuf[0] = 12'h003; wbuf[1] = 12'h777; wbuf[2] = 12'h088; wbuf[3] = 12'h999;
    frame(0, 4, 0, 1'b0, "R7");
    model(0, 4);
    chk_all("R7 soft reset within burst");

    // R1/R3: arithmetic pattern sweep, four-word bursts
    for (int k = 0; k < 8; k++) begin
      for (int r = 0; r < NREG; r++) wbuf[r] = (r * 1109 + k * 397 + 5) & 12'hFFF;
      wbuf[0] = wbuf[0] & 12'hFFE;
      frame(0, 4, 0, 1'b0, "R1");
      model(0, 4);
      chk_all("R1 pattern burst");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule